// File: doc/BRIEF.md
# CPU Memory Write Sequencer

This block is the memory-side controller of a small two-stage 32-bit processor. In idle cycles it puts the fetch address from the core on a synchronous memory bus and registers the returned instruction word as the current opcode. When the executing instruction needs a data access, the block first fetches the following opcode into a side register. It then runs the load or store on the same bus. When the access is done, it issues that saved opcode.

Stores to slow memory without a clock are stretched. The address and write data are driven for one cycle before and one cycle after a single-cycle write strobe. Stores to the clocked region, which is any address with bit 31 set, strobe at once. Byte and halfword stores are steered onto the correct byte lanes for big-endian order, or for little-endian order when the configuration input selects it. Loads return the addressed lanes, zero-extended. A pause input from the bus freezes the whole sequence.

Top module: `memwr_seq`

## Requirements
- R1: While reset is high, `opcode_o` is 0, `op_valid_o` is 0, and `mem_we_o`, `mem_bsel_o` and `mem_wdata_o` are all 0.
- R2: In an idle cycle with no access requested, `mem_addr_o` equals `pc_i` and `stall_o` is low. The word read in that cycle appears on `opcode_o` from the next cycle on, and `op_valid_o` is 1 from then on.
- R3: A store to an address with bit 31 clear takes four cycles. Cycle 0 fetches at `pc_i`. Cycles 1 to 3 drive the store address. `mem_we_o` is 1 only in cycle 2. `stall_o` is high in cycles 0 to 2 and low in cycle 3.
- R4: In a four-cycle store, `mem_addr_o`, `mem_wdata_o` and `mem_bsel_o` stay constant over cycles 1 to 3.
- R5: A store to an address with bit 31 set takes two cycles. Cycle 0 fetches at `pc_i`. Cycle 1 drives the store address with `mem_we_o` at 1 and `stall_o` low.
- R6: During any access sequence `opcode_o` keeps its old value. After the last cycle it shows the word read at `pc_i` in cycle 0.
- R7: `acc_size_i` is coded 0 = byte, 1 = halfword, 2 or 3 = word. Lane k is `mem_bsel_o[k]`, which covers data bits 8k+7..8k. With `cfg_little_i` = 0, the byte at address offset k uses lane 3-k. A halfword at offset 0 uses lanes 3:2 and one at offset 2 uses lanes 1:0.
- R8: With `cfg_little_i` = 1, the byte at offset k uses lane k. A halfword at offset 0 uses lanes 1:0 and one at offset 2 uses lanes 3:2. A word store enables all four lanes in either order.
- R9: During a store's address cycles, `mem_wdata_o` holds the low byte of `acc_wdata_i` repeated in all four lanes for a byte store. It holds the low halfword repeated twice for a halfword store, and the whole word for a word store.
- R10: A load takes two cycles. Cycle 0 fetches at `pc_i`. In cycle 1, `mem_addr_o` is the load address, `mem_we_o` is 0, `mem_bsel_o` is 0 and `stall_o` is low. From the next cycle on, `load_data_o` holds the lanes picked per R7/R8, zero-extended.
- R11: While `mem_pause_i` is 1, `stall_o` is 1 and the sequence does not advance. The bus outputs, `opcode_o` and `load_data_o` hold their values until the pause ends.
- R12: Outside a store's address cycles, `mem_bsel_o` and `mem_wdata_o` are 0 and `mem_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_little_i | input | 1 | 1 selects little-endian lane order |
| pc_i | input | 32 | Fetch address from the core |
| acc_valid_i | input | 1 | Executing instruction requests a data access |
| acc_store_i | input | 1 | 1 = store, 0 = load |
| acc_size_i | input | 2 | Access size code (R7) |
| acc_addr_i | input | 32 | Data access address |
| acc_wdata_i | input | 32 | Store data, right-aligned |
| stall_o | output | 1 | Core must hold its PC this cycle |
| opcode_o | output | 32 | Opcode issued to execute |
| op_valid_o | output | 1 | At least one opcode has been fetched since reset |
| load_data_o | output | 32 | Result of the last load |
| mem_addr_o | output | 32 | Bus address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_rdata_i | input | 32 | Bus read data, valid in the same cycle |
| mem_bsel_o | output | 4 | Byte lanes written |
| mem_we_o | output | 1 | Write strobe |
| mem_pause_i | input | 1 | Bus wait state, freezes the block |

## Verification
A wrong sequence state shows on the bus within one cycle. It appears as a strobe in the wrong cycle, a store address in a fetch slot, or a stall level that lets the core move its PC early. A fault in the saved next-opcode register or the lane registers only shows later. It surfaces as a wrong `opcode_o` or `load_data_o` in the cycle after the sequence ends. For that reason, every cycle of every sequence is compared against expected bus values, and the issued opcode is checked in every cycle. Pauses are placed both at the fetch and at the strobe, so that a state that drifts during a pause shows up as an early or repeated strobe.

// File: rtl/memwr_pkg.sv
package memwr_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_PRE     = 3'd1,
        SQ_STROBE  = 3'd2,
        SQ_POST    = 3'd3,
        SQ_FAST_WR = 3'd4,
        SQ_LOAD    = 3'd5
    } seq_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/memwr_lanes.sv
module memwr_lanes #(
    parameter int unsigned DW = 32
) (
    input  logic [1:0]      size_i,
    input  logic [1:0]      off_i,
    input  logic            little_i,
    input  logic [DW-1:0]   data_i,
    output logic [DW/8-1:0] bsel_o,
    output logic [DW-1:0]   data_o
);
    import memwr_pkg::*;

    localparam int unsigned NL = DW / 8;

    logic [1:0] byte_lane;
    logic       half_pair;

    assign byte_lane = little_i ? off_i : (2'(NL - 1) - off_i);
    assign half_pair = little_i ? off_i[1] : ~off_i[1];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        always_comb begin
            if (size_i == SZ_BYTE)      bsel_o[g] = (byte_lane == 2'(g));
            else if (size_i == SZ_HALF) bsel_o[g] = (half_pair == 1'(g / 2));
            else                        bsel_o[g] = 1'b1;
        end
    end

    always_comb begin
        if (size_i == SZ_BYTE)      data_o = {NL{data_i[7:0]}};
        else if (size_i == SZ_HALF) data_o = {(NL / 2){data_i[15:0]}};
        else                        data_o = data_i;
    end

endmodule

// File: rtl/memwr_extract.sv
module memwr_extract #(
    parameter int unsigned DW = 32
) (
    input  logic [1:0]    size_i,
    input  logic [1:0]    off_i,
    input  logic          little_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] data_o
);
    import memwr_pkg::*;

    localparam int unsigned NL = DW / 8;

    logic [7:0] lanes [NL];
    logic [1:0] byte_lane;
    logic       half_pair;
    logic [1:0] hi_lane;
    logic [1:0] lo_lane;

    for (genvar g = 0; g < NL; g++) begin : g_split
        assign lanes[g] = rdata_i[8*g +: 8];
    end

    assign byte_lane = little_i ? off_i : (2'(NL - 1) - off_i);
    assign half_pair = little_i ? off_i[1] : ~off_i[1];
    assign hi_lane   = {half_pair, 1'b1};
    assign lo_lane   = {half_pair, 1'b0};

    always_comb begin
        if (size_i == SZ_BYTE)      data_o = {{(DW - 8){1'b0}}, lanes[byte_lane]};
        else if (size_i == SZ_HALF) data_o = {{(DW - 16){1'b0}}, lanes[hi_lane], lanes[lo_lane]};
        else                        data_o = rdata_i;
    end

endmodule

// File: rtl/memwr_seq.sv
module memwr_seq #(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned FAST_BIT = AW - 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            cfg_little_i,
    input  logic [AW-1:0]   pc_i,
    input  logic            acc_valid_i,
    input  logic            acc_store_i,
    input  logic [1:0]      acc_size_i,
    input  logic [AW-1:0]   acc_addr_i,
    input  logic [DW-1:0]   acc_wdata_i,
    output logic            stall_o,
    output logic [DW-1:0]   opcode_o,
    output logic            op_valid_o,
    output logic [DW-1:0]   load_data_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [DW/8-1:0] mem_bsel_o,
    output logic            mem_we_o,
    input  logic            mem_pause_i
);
    import memwr_pkg::*;

    localparam int unsigned NL = DW / 8;

    typedef struct packed {
        seq_state_e    state;
        logic [DW-1:0] opcode;
        logic [DW-1:0] next_op;
        logic [DW-1:0] wdata;
        logic [DW-1:0] ldata;
        logic [AW-1:0] addr;
        logic [NL-1:0] bsel;
        logic [1:0]    size;
        logic          little;
        logic          setup;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NL-1:0] steer_bsel;
    logic [DW-1:0] steer_wdata;
    logic [DW-1:0] picked_rdata;

    memwr_lanes #(.DW(DW)) u_lanes (
        .size_i   (acc_size_i),
        .off_i    (acc_addr_i[1:0]),
        .little_i (cfg_little_i),
        .data_i   (acc_wdata_i),
        .bsel_o   (steer_bsel),
        .data_o   (steer_wdata)
    );

    memwr_extract #(.DW(DW)) u_extract (
        .size_i   (seq_q.size),
        .off_i    (seq_q.addr[1:0]),
        .little_i (seq_q.little),
        .rdata_i  (mem_rdata_i),
        .data_o   (picked_rdata)
    );

    // Next-state and bus drive
    always_comb begin
        seq_d       = seq_q;
        mem_addr_o  = pc_i;
        mem_wdata_o = '0;
        mem_bsel_o  = '0;
        mem_we_o    = 1'b0;
        stall_o     = mem_pause_i;

        unique case (seq_q.state)
            SQ_IDLE: begin
                if (acc_valid_i) begin
                    stall_o = 1'b1;
                    if (!mem_pause_i) begin
                        seq_d.next_op = mem_rdata_i;
                        seq_d.addr    = acc_addr_i;
                        seq_d.size    = acc_size_i;
                        seq_d.little  = cfg_little_i;
                        seq_d.wdata   = steer_wdata;
                        seq_d.bsel    = steer_bsel;
                        if (!acc_store_i)             seq_d.state = SQ_LOAD;
                        else if (acc_addr_i[FAST_BIT]) seq_d.state = SQ_FAST_WR;
                        else                           seq_d.state = SQ_PRE;
                    end
                end else if (!mem_pause_i) begin
                    seq_d.opcode = mem_rdata_i;
                    seq_d.setup  = 1'b1;
                end
            end
            SQ_PRE: begin
                mem_addr_o  = seq_q.addr;
                mem_wdata_o = seq_q.wdata;
                mem_bsel_o  = seq_q.bsel;
                stall_o     = 1'b1;
                if (!mem_pause_i) seq_d.state = SQ_STROBE;
            end
            SQ_STROBE: begin
                mem_addr_o  = seq_q.addr;
                mem_wdata_o = seq_q.wdata;
                mem_bsel_o  = seq_q.bsel;
                mem_we_o    = 1'b1;
                stall_o     = 1'b1;
                if (!mem_pause_i) seq_d.state = SQ_POST;
            end
            SQ_POST, SQ_FAST_WR: begin
                mem_addr_o  = seq_q.addr;
                mem_wdata_o = seq_q.wdata;
                mem_bsel_o  = seq_q.bsel;
                mem_we_o    = (seq_q.state == SQ_FAST_WR);
                if (!mem_pause_i) begin
                    seq_d.state  = SQ_IDLE;
                    seq_d.opcode = seq_q.next_op;
                    seq_d.setup  = 1'b1;
                end
            end
            SQ_LOAD: begin
                mem_addr_o = seq_q.addr;
                if (!mem_pause_i) begin
                    seq_d.state  = SQ_IDLE;
                    seq_d.ldata  = picked_rdata;
                    seq_d.opcode = seq_q.next_op;
                    seq_d.setup  = 1'b1;
                end
            end
            default: seq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign opcode_o    = seq_q.opcode;
    assign op_valid_o  = seq_q.setup;
    assign load_data_o = seq_q.ldata;

endmodule

// File: rtl/memwr_seq_chk.sv
module memwr_seq_chk #(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter int unsigned FAST_BIT = AW - 1
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            stall_o,
    input logic [DW-1:0]   opcode_o,
    input logic [DW-1:0]   load_data_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic [DW-1:0]   mem_wdata_o,
    input logic [DW/8-1:0] mem_bsel_o,
    input logic            mem_we_o,
    input logic            mem_pause_i
);

    // R3: the strobe lasts exactly one unpaused cycle
    p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_we_o && !mem_pause_i) |=> !mem_we_o);

    // R3: a slow-memory strobe keeps the core stalled
    p_stall_slow_strobe_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_we_o && !mem_addr_o[FAST_BIT]) |-> stall_o);

    // R4: address and data already stable in the cycle before a slow strobe
    p_hold_before_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(mem_we_o) && !mem_addr_o[FAST_BIT]) |-> ($stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R4: address and data held in the cycle after a slow strobe
    p_hold_after_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_we_o && !mem_pause_i && !mem_addr_o[FAST_BIT]) |=> ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_bsel_o)));

    // R5: a clocked-region strobe is followed straight away by an idle bus
    p_fast_release_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_we_o && !mem_pause_i && mem_addr_o[FAST_BIT]) |=> (mem_bsel_o == '0));

    // R7: lane enables are one, two or four lanes, never three
    p_lane_count_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(mem_bsel_o) != 3);

    // R11: a pause freezes sequence state visible at the ports
    p_pause_freeze_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_pause_i |=> ($stable(opcode_o) && $stable(mem_we_o) && $stable(mem_bsel_o) && $stable(load_data_o)));

    // R11: a pause always stalls the core
    p_pause_stall_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_pause_i |-> stall_o);

    // R12: no lanes means no data and no strobe
    p_idle_bus_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_bsel_o == '0) |-> (mem_wdata_o == '0 && !mem_we_o));

endmodule

bind memwr_seq memwr_seq_chk #(.AW(AW), .DW(DW), .FAST_BIT(FAST_BIT)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .stall_o     (stall_o),
    .opcode_o    (opcode_o),
    .load_data_o (load_data_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_bsel_o  (mem_bsel_o),
    .mem_we_o    (mem_we_o),
    .mem_pause_i (mem_pause_i)
);

// File: tb/memwr_seq_bench.sv
module memwr_seq_bench;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        cfg_little_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic        acc_valid_i = 1'b0;
    logic        acc_store_i = 1'b0;
    logic [1:0]  acc_size_i = '0;
    logic [31:0] acc_addr_i = '0;
    logic [31:0] acc_wdata_i = '0;
    logic        stall_o;
    logic [31:0] opcode_o;
    logic        op_valid_o;
    logic [31:0] load_data_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic [3:0]  mem_bsel_o;
    logic        mem_we_o;
    logic        mem_pause_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_op = '0;
    logic        exp_valid = 1'b0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] rd_fn(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C5A, a[31:16] ^ 16'h9E01} + 32'h0102_0304;
    endfunction

    assign mem_rdata_i = rd_fn(mem_addr_o);

    memwr_seq u_memwr_seq (
        .clk_i(clk), .rst_i(rst_i), .cfg_little_i(cfg_little_i), .pc_i(pc_i),
        .acc_valid_i(acc_valid_i), .acc_store_i(acc_store_i), .acc_size_i(acc_size_i),
        .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i), .stall_o(stall_o),
        .opcode_o(opcode_o), .op_valid_o(op_valid_o), .load_data_o(load_data_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .mem_bsel_o(mem_bsel_o), .mem_we_o(mem_we_o), .mem_pause_i(mem_pause_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected lanes per R7/R8
    function automatic logic [3:0] exp_bsel(input logic [1:0] sz, input logic [1:0] off, input logic lil);
        if (sz == 2'd0) begin
            case (off)
                2'd0: return lil ? 4'b0001 : 4'b1000;
                2'd1: return lil ? 4'b0010 : 4'b0100;
                2'd2: return lil ? 4'b0100 : 4'b0010;
                default: return lil ? 4'b1000 : 4'b0001;
            endcase
        end
        if (sz == 2'd1) return (off[1] ^ lil) ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    // Expected replicated write data per R9
    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
        if (sz == 2'd1) return {d[15:0], d[15:0]};
        return d;
    endfunction

    // Expected load result per R10
    function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] off, input logic lil, input logic [31:0] w);
        logic [3:0] m;
        m = exp_bsel(sz, off, lil);
        if (sz == 2'd0) begin
            case (m)
                4'b1000: return {24'd0, w[31:24]};
                4'b0100: return {24'd0, w[23:16]};
                4'b0010: return {24'd0, w[15:8]};
                default: return {24'd0, w[7:0]};
            endcase
        end
        if (sz == 2'd1) return (m == 4'b1100) ? {16'd0, w[31:16]} : {16'd0, w[15:0]};
        return w;
    endfunction

    task automatic check_bus(input string req, input logic [31:0] a, input logic we,
                             input logic [3:0] bs, input logic [31:0] wd, input logic st);
        check({req, " addr"}, mem_addr_o, a);
        check({req, " we"}, {31'd0, mem_we_o}, {31'd0, we});
        check({req, " bsel"}, {28'd0, mem_bsel_o}, {28'd0, bs});
        check({req, " wdata"}, mem_wdata_o, wd);
        check({req, " stall"}, {31'd0, stall_o}, {31'd0, st});
        check("R6 opcode", opcode_o, exp_op);
        check("R2 op_valid", {31'd0, op_valid_o}, {31'd0, exp_valid});
    endtask

    task automatic idle_cycle(input logic [31:0] p, input int pause_n);
        pc_i = p;
        acc_valid_i = 1'b0;
        for (int i = 0; i < pause_n; i++) begin
            mem_pause_i = 1'b1;
            #2 check_bus("R11 paused idle", p, 1'b0, 4'd0, 32'd0, 1'b1);
            @(negedge clk);
        end
        mem_pause_i = 1'b0;
        #2 check_bus("R2 idle", p, 1'b0, 4'd0, 32'd0, 1'b0);
        @(negedge clk);
        exp_op = rd_fn(p);
        exp_valid = 1'b1;
    endtask

    // kind: 0 load, 1 store. pause_at: cycle index to pause for two cycles, -1 none.
    task automatic access(input logic kind, input logic [31:0] p, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] d, input logic lil, input int pause_at);
        logic [3:0]  eb;
        logic [31:0] ew;
        int          ncyc;
        logic        we_e, st_e;
        logic [31:0] a_e;
        logic [3:0]  b_e;
        logic [31:0] w_e;
        string       tag;
        eb = exp_bsel(sz, a[1:0], lil);
        ew = exp_wd(sz, d);
        ncyc = (kind == 1'b0) ? 2 : (a[31] ? 2 : 4);
        tag = (kind == 1'b0) ? "R10 load" : (a[31] ? "R5 fast store" : "R3 slow store");
        pc_i = p; cfg_little_i = lil; acc_valid_i = 1'b1; acc_store_i = kind;
        acc_size_i = sz; acc_addr_i = a; acc_wdata_i = d;
        for (int c = 0; c < ncyc; c++) begin
            a_e = (c == 0) ? p : a;
            b_e = (c == 0 || kind == 1'b0) ? 4'd0 : eb;
            w_e = (c == 0 || kind == 1'b0) ? 32'd0 : ew;
            we_e = (kind == 1'b1) && ((ncyc == 4 && c == 2) || (ncyc == 2 && c == 1));
            st_e = (c != ncyc - 1);
            for (int r = 0; r < ((c == pause_at) ? 3 : 1); r++) begin
                mem_pause_i = (c == pause_at) && (r < 2);
                #2 check_bus(mem_pause_i ? {"R11 ", tag} : ((kind && c > 0) ? {"R4 R9 ", tag} : tag),
                             a_e, we_e, b_e, w_e, st_e | mem_pause_i);
                if (kind && c > 0) check("R7 R8 lanes", {28'd0, mem_bsel_o}, {28'd0, eb});
                @(negedge clk);
            end
            mem_pause_i = 1'b0;
            if (c == 0) begin
                acc_valid_i = 1'b0;
                acc_addr_i = 32'hDEAD_BEE0;
                acc_wdata_i = 32'h5555_AAAA;
                acc_size_i = 2'd0;
            end
        end
        exp_op = rd_fn(p);
        exp_valid = 1'b1;
        if (kind == 1'b0) begin
            #2 check("R10 load data", load_data_o, exp_ld(sz, a[1:0], lil, rd_fn(a)));
            check("R6 after access", opcode_o, exp_op);
            check("R12 idle after", {28'd0, mem_bsel_o}, 4'd0);
            #0;
        end else begin
            #2 check("R12 idle after store", {28'd0, mem_bsel_o}, 4'd0);
            check("R6 after store", opcode_o, exp_op);
        end
        // Back to the negedge alignment
        @(negedge clk);
        pc_i = p + 32'd4;
        #2 check_bus("R2 resume", p + 32'd4, 1'b0, 4'd0, 32'd0, 1'b0);
        @(negedge clk);
        exp_op = rd_fn(p + 32'd4);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc;
        void'($urandom(32'd1234));
        rst_i = 1'b1;
        pc_i = 32'h0000_0100;
        repeat (3) @(negedge clk);
        #2;
        check("R1 opcode", opcode_o, 32'd0);
        check("R1 op_valid", {31'd0, op_valid_o}, 32'd0);
        check("R1 we", {31'd0, mem_we_o}, 32'd0);
        check("R1 bsel", {28'd0, mem_bsel_o}, 32'd0);
        check("R1 wdata", mem_wdata_o, 32'd0);
        @(negedge clk);
        rst_i = 1'b0;

        pc = 32'h0000_0100;
        idle_cycle(pc, 0); pc += 4;
        idle_cycle(pc, 0); pc += 4;
        idle_cycle(pc, 2); pc += 4;

        // Directed stores: every byte offset, both orders, slow memory
        for (int e = 0; e < 2; e++) begin
            for (int o = 0; o < 4; o++) begin
                access(1'b1, pc, 32'h0000_FFFC | 32'(o), 2'd0, 32'h1234_5631, e[0], -1);
                pc += 8;
            end
            access(1'b1, pc, 32'h0000_2000, 2'd1, 32'h0000_BEEF, e[0], -1); pc += 8;
            access(1'b1, pc, 32'h0000_2002, 2'd1, 32'h0000_CAFE, e[0], -1); pc += 8;
            access(1'b1, pc, 32'h8000_0040, 2'd0, 32'h0000_0077, e[0], -1); pc += 8;
            for (int o = 0; o < 4; o++) begin
                access(1'b0, pc, 32'h0000_3000 | 32'(o), 2'd0, 32'd0, e[0], -1);
                pc += 8;
            end
            access(1'b0, pc, 32'h0000_3002, 2'd1, 32'd0, e[0], -1); pc += 8;
        end
        access(1'b1, pc, 32'h0000_4000, 2'd2, 32'hA1B2_C3D4, 1'b0, -1); pc += 8;
        access(1'b1, pc, 32'h8000_4000, 2'd3, 32'hA1B2_C3D4, 1'b1, -1); pc += 8;
        access(1'b0, pc, 32'h0000_5000, 2'd2, 32'd0, 1'b0, -1); pc += 8;
        // Pauses at fetch, before, at and after the strobe, and in a load
        access(1'b1, pc, 32'h0000_6001, 2'd0, 32'h0000_0042, 1'b0, 0); pc += 8;
        access(1'b1, pc, 32'h0000_6002, 2'd1, 32'h0000_9988, 1'b0, 1); pc += 8;
        access(1'b1, pc, 32'h0000_6000, 2'd2, 32'h0BAD_F00D, 1'b1, 2); pc += 8;
        access(1'b1, pc, 32'h0000_6003, 2'd0, 32'h0000_0011, 1'b1, 3); pc += 8;
        access(1'b1, pc, 32'h8000_6000, 2'd2, 32'h1357_9BDF, 1'b0, 1); pc += 8;
        access(1'b0, pc, 32'h0000_7001, 2'd0, 32'd0, 1'b1, 1); pc += 8;

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned kind_r;
            logic [31:0] a;
            logic [1:0]  sz;
            kind_r = $urandom_range(0, 2);
            sz = 2'($urandom_range(0, 3));
            a = $urandom;
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz[1]) a[1:0] = 2'b00;
            pc = {$urandom_range(0, 16'hFFFF), 2'b00};
            if (kind_r == 0) begin
                idle_cycle(pc, ($urandom_range(0, 4) == 0) ? 1 : 0);
            end else begin
                access(kind_r == 1 ? 1'b0 : 1'b1, pc, a, sz, $urandom, 1'($urandom_range(0, 1)),
                       ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 3)) : -1);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule